// File: doc/BRIEF.md
# I2C Master Byte-Transfer Controller

This block is a register-driven I2C bus master that moves a single byte per software command. Software programs a data register with an address or payload byte, writes a status register to pick the transfer direction and to request START, and the controller clocks out the byte MSB first followed by a ninth acknowledge clock. After every byte the controller raises a pending flag, optionally signals an interrupt, and parks the bus with SCL held low until software clears the flag. Clearing the flag either continues with the next byte, issues a repeated START, or issues STOP, depending on what software last wrote to the status register.

The SCL rate comes from a two-step divider: a coarse prescaler of 16 or 512 system clocks followed by a 4-bit divider. During reception the master acknowledges each byte or not according to a control bit, so software turns that bit off before the final byte of a read. A register read from a slave is a write of the chip and register address bytes in transmit mode, then a repeated START in receive mode with the chip address again.

Both bus lines are open drain: the block only ever pulls a line low or releases it, and it reads the data line back through an input pin.

Top module: `i2cm_byte_ctrl`

## Requirements
- R1: After reset the control (offset 0), status (offset 1), data (offset 2) and own-address (offset 3) registers read 0, neither bus line is pulled low and the interrupt output is low.
- R2: Writing the status register with bit 7, bit 5 and bit 4 set while the bus is idle issues START and shifts out the data register MSB first; in mode 11 (status bits 7:6) each later byte is taken from the data register.
- R3: When the ninth clock of a byte ends, control bit 4 (pending) becomes 1 and SCL stays pulled low until software writes the control register with bit 4 equal to 0.
- R4: Status bit 0 holds the SDA level sampled on the ninth clock of the last transmitted byte: 0 for ACK, 1 for NACK.
- R5: In mode 10 each received byte is placed MSB first into the data register; on its ninth clock the master pulls SDA low when control bit 7 is 1 and leaves it released (NACK) when control bit 7 is 0.
- R6: One SCL period lasts P × (control bits 3:0 + 1) system clocks, with P equal to 16, or 512 when control bit 6 is 1.
- R7: SDA changes only while SCL is low, except for START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high).
- R8: Status bit 5 reads 1 from START until STOP completes and 0 otherwise; while it reads 0 both lines are released.
- R9: Writing control bit 4 as 1 leaves the pending flag unchanged, whether it is set or clear.
- R10: A status write with bit 5 equal to 0 during a stall, followed by clearing the pending flag, generates STOP.
- R11: A status write with bit 5 equal to 1 during a stall, followed by clearing the pending flag, generates a repeated START and sends the data register as an address byte; later bytes follow the mode in status bits 7:6.
- R12: The interrupt output is 1 exactly while the pending flag and control bit 5 are both 1.
- R13: A status write requesting START with bit 4 equal to 0 starts nothing and the bus stays released.
- R14: The own-address register at offset 3 holds the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr |
| irq | output | 1 | Interrupt request |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The bench builds the block with its default prescalers of 16 and 512 and reprograms the 4-bit divider and the prescaler select between bytes, so SCL periods of 16, 48 and 512 system clocks are measured within one transaction. The short 16-cycle setting keeps whole write, NACK and repeated-START read sequences cheap enough to run them all, while the 512 setting shows that the coarse prescaler is actually reached. An open-drain slave model that acknowledges one address checks bit order, the acknowledge sampling point and the final NACK from the bus side.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 4;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_DATA = 2'd2;
    localparam logic [1:0] OFS_OWN  = 2'd3;

    // control register bit positions
    localparam int C_ACK  = 7;
    localparam int C_PRE  = 6;
    localparam int C_IEN  = 5;
    localparam int C_PEND = 4;

    // status register bit positions
    localparam int S_MODE_HI = 7;
    localparam int S_MODE_TX = 6;
    localparam int S_SS      = 5;
    localparam int S_EN      = 4;
    localparam int S_ACK     = 0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_BIT,
        SQ_HOLD,
        SQ_RSTART,
        SQ_STOP
    } seq_state_e;

    typedef struct packed {
        seq_state_e         st;
        logic [1:0]         q;
        logic [3:0]         bitc;
        logic [BYTE_W-1:0]  sh;
        logic               tx;
        logic               scl;
        logic               sda;
        logic               ackb;
    } seq_reg_t;

    typedef struct packed {
        logic               ack_en;
        logic               pre_hi;
        logic               ien;
        logic               pend;
        logic [DIV_W-1:0]   div;
        logic [1:0]         mode;
        logic               ss;
        logic               txen;
        logic               ackf;
        logic               rs;
        logic [BYTE_W-1:0]  data;
        logic [BYTE_W-1:0]  own;
    } regs_t;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick
    import i2cm_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_hi,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    // one tick per quarter of an SCL period
    localparam int QLO    = PRE_LO / 4;
    localparam int QHI    = PRE_HI / 4;
    localparam int MAXLEN = QHI * (2 ** DIV_W);
    localparam int CW     = $clog2(MAXLEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] base;
    logic [CW-1:0] len;
    logic          at_end;

    always_comb begin
        base   = pre_hi ? CW'(QHI) : CW'(QLO);
        len    = base * ({{(CW-DIV_W){1'b0}}, div} + CW'(1));
        at_end = (cnt_q == len - CW'(1));
        tick   = run && at_end;
        if (!run || at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_start,
    input  logic              go_resume,
    input  logic              want_stop,
    input  logic              want_restart,
    input  logic              tx_mode,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_in,
    output logic              scl_rel,
    output logic              sda_rel,
    output logic              busy,
    output logic              run,
    output logic              in_bit,
    output logic              byte_done,
    output logic              done_tx,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_seen
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

    seq_reg_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        byte_done = 1'b0;
        unique case (r_q.st)
            SQ_IDLE: begin
                r_d.scl = 1'b1;
                r_d.sda = 1'b1;
                if (go_start) begin
                    r_d.st  = SQ_START;
                    r_d.q   = 2'd0;
                    r_d.sda = 1'b0;          // SDA falls, SCL high
                    r_d.sh  = tx_byte;
                end
            end
            SQ_START: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    if (r_q.q == 2'd1) begin
                        r_d.scl  = 1'b0;
                        r_d.st   = SQ_BIT;
                        r_d.q    = 2'd0;
                        r_d.bitc = 4'd0;
                        r_d.tx   = 1'b1;
                    end
                end
            end
            SQ_BIT: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    unique case (r_q.q)
                        2'd0: begin
                            if (r_q.bitc == ACK_SLOT) begin
                                r_d.sda = r_q.tx ? 1'b1 : !ack_en;
                            end else begin
                                r_d.sda = r_q.tx ? r_q.sh[BYTE_W-1] : 1'b1;
                            end
                        end
                        2'd1: r_d.scl = 1'b1;
                        2'd2: begin
                            if (r_q.bitc == ACK_SLOT) begin
                                r_d.ackb = sda_in;
                            end else begin
                                r_d.sh = {r_q.sh[BYTE_W-2:0], sda_in};
                            end
                        end
                        default: begin
                            r_d.scl = 1'b0;
                            if (r_q.bitc == ACK_SLOT) begin
                                r_d.st    = SQ_HOLD;
                                byte_done = 1'b1;
                            end else begin
                                r_d.bitc = r_q.bitc + 4'd1;
                            end
                        end
                    endcase
                end
            end
            SQ_HOLD: begin
                if (go_resume) begin
                    r_d.q = 2'd0;
                    if (want_stop) begin
                        r_d.st = SQ_STOP;
                    end else if (want_restart) begin
                        r_d.st = SQ_RSTART;
                    end else begin
                        r_d.st   = SQ_BIT;
                        r_d.bitc = 4'd0;
                        r_d.sh   = tx_byte;
                        r_d.tx   = tx_mode;
                    end
                end
            end
            SQ_RSTART: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    unique case (r_q.q)
                        2'd0: r_d.sda = 1'b1;
                        2'd1: r_d.scl = 1'b1;
                        2'd2: r_d.sda = 1'b0;
                        default: begin
                            r_d.scl  = 1'b0;
                            r_d.st   = SQ_BIT;
                            r_d.bitc = 4'd0;
                            r_d.sh   = tx_byte;
                            r_d.tx   = 1'b1;
                        end
                    endcase
                end
            end
            SQ_STOP: begin
                if (tick) begin
                    r_d.q = r_q.q + 2'd1;
                    unique case (r_q.q)
                        2'd0: r_d.sda = 1'b0;
                        2'd1: r_d.scl = 1'b1;
                        default: begin
                            r_d.sda = 1'b1;
                            r_d.st  = SQ_IDLE;
                        end
                    endcase
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase

        scl_rel  = r_q.scl;
        sda_rel  = r_q.sda;
        busy     = (r_q.st != SQ_IDLE);
        run      = (r_q.st == SQ_START) || (r_q.st == SQ_BIT) ||
                   (r_q.st == SQ_RSTART) || (r_q.st == SQ_STOP);
        in_bit   = (r_q.st == SQ_BIT);
        done_tx  = r_q.tx;
        rx_byte  = r_q.sh;
        ack_seen = r_q.ackb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= SQ_IDLE;
            r_q.scl  <= 1'b1;
            r_q.sda  <= 1'b1;
            r_q.ackb <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              busy,
    input  logic              byte_done,
    input  logic              done_tx,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ack_seen,
    output logic              go_start,
    output logic              go_resume,
    output logic              want_stop,
    output logic              want_restart,
    output logic              tx_mode,
    output logic              ack_en,
    output logic              pre_hi,
    output logic [DIV_W-1:0]  div,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              pend,
    output logic              irq
);
    regs_t g_q, g_d;
    logic  wr_ctrl, wr_stat, wr_data, wr_own;

    always_comb begin
        g_d     = g_q;
        wr_ctrl = wr_en && (addr == OFS_CTRL);
        wr_stat = wr_en && (addr == OFS_STAT);
        wr_data = wr_en && (addr == OFS_DATA);
        wr_own  = wr_en && (addr == OFS_OWN);

        go_start  = wr_stat && wdata[S_MODE_HI] && wdata[S_SS] &&
                    wdata[S_EN] && !busy;
        go_resume = wr_ctrl && !wdata[C_PEND] && g_q.pend;

        if (wr_ctrl) begin
            g_d.ack_en = wdata[C_ACK];
            g_d.pre_hi = wdata[C_PRE];
            g_d.ien    = wdata[C_IEN];
            g_d.div    = wdata[DIV_W-1:0];
            g_d.pend   = g_q.pend && wdata[C_PEND];
        end
        if (go_resume) begin
            g_d.rs = 1'b0;
        end
        if (wr_stat) begin
            g_d.mode = wdata[S_MODE_HI:S_MODE_TX];
            g_d.ss   = wdata[S_SS];
            g_d.txen = wdata[S_EN];
            g_d.rs   = busy && wdata[S_SS];
        end
        if (wr_data) begin
            g_d.data = wdata;
        end
        if (wr_own) begin
            g_d.own = wdata;
        end
        if (byte_done) begin
            g_d.pend = 1'b1;
            if (done_tx) begin
                g_d.ackf = ack_seen;
            end else begin
                g_d.data = rx_byte;
            end
        end

        unique case (addr)
            OFS_CTRL: rdata = {g_q.ack_en, g_q.pre_hi, g_q.ien, g_q.pend, g_q.div};
            OFS_STAT: rdata = {g_q.mode, busy, g_q.txen, 3'b000, g_q.ackf};
            OFS_DATA: rdata = g_q.data;
            default:  rdata = g_q.own;
        endcase

        want_stop    = !g_q.ss;
        want_restart = g_q.rs;
        tx_mode      = g_q.mode[0];
        ack_en       = g_q.ack_en;
        pre_hi       = g_q.pre_hi;
        div          = g_q.div;
        tx_byte      = g_q.data;
        pend         = g_q.pend;
        irq          = g_q.pend && g_q.ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/i2cm_byte_ctrl.sv
module i2cm_byte_ctrl
    import i2cm_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    logic              tick_w, run_w, busy_w, in_bit_w, done_w, done_tx_w;
    logic              ack_seen_w, scl_rel_w, sda_rel_w;
    logic              go_start_w, go_resume_w, want_stop_w, want_restart_w;
    logic              tx_mode_w, ack_en_w, pre_hi_w, pend_w;
    logic [DIV_W-1:0]  div_w;
    logic [BYTE_W-1:0] rx_byte_w, tx_byte_w;

    i2cm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .pre_hi (pre_hi_w),
        .div    (div_w),
        .tick   (tick_w)
    );

    i2cm_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .busy         (busy_w),
        .byte_done    (done_w),
        .done_tx      (done_tx_w),
        .rx_byte      (rx_byte_w),
        .ack_seen     (ack_seen_w),
        .go_start     (go_start_w),
        .go_resume    (go_resume_w),
        .want_stop    (want_stop_w),
        .want_restart (want_restart_w),
        .tx_mode      (tx_mode_w),
        .ack_en       (ack_en_w),
        .pre_hi       (pre_hi_w),
        .div          (div_w),
        .tx_byte      (tx_byte_w),
        .pend         (pend_w),
        .irq          (irq)
    );

    i2cm_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_w),
        .go_start     (go_start_w),
        .go_resume    (go_resume_w),
        .want_stop    (want_stop_w),
        .want_restart (want_restart_w),
        .tx_mode      (tx_mode_w),
        .ack_en       (ack_en_w),
        .tx_byte      (tx_byte_w),
        .sda_in       (sda_in),
        .scl_rel      (scl_rel_w),
        .sda_rel      (sda_rel_w),
        .busy         (busy_w),
        .run          (run_w),
        .in_bit       (in_bit_w),
        .byte_done    (done_w),
        .done_tx      (done_tx_w),
        .rx_byte      (rx_byte_w),
        .ack_seen     (ack_seen_w)
    );

    assign scl_drive_low = !scl_rel_w;
    assign sda_drive_low = !sda_rel_w;

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic pend,
    input logic busy,
    input logic in_bit,
    input logic byte_done
);
    // R3: a set pending flag always coincides with SCL pulled low
    a_r3_stall_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> scl_drive_low);

    // R3: the cycle after a byte completes, the pending flag is set
    a_r3_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> pend);

    // R2: completion is a single-cycle event
    a_r2_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R7: inside a byte, SDA is steady while SCL stays released
    a_r7_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bit && $past(in_bit) && !scl_drive_low && $past(!scl_drive_low))
            |-> $stable(sda_drive_low));

    // R8: an idle controller releases both lines
    a_r8_idle_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low));

endmodule

bind i2cm_byte_ctrl i2cm_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .pend          (pend_w),
    .busy          (busy_w),
    .in_bit        (in_bit_w),
    .byte_done     (done_w)
);

// File: tb/i2cm_byte_ctrl_bench.sv
module i2cm_byte_ctrl_bench;

    localparam logic [6:0] SLV = 7'h50;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_OWN = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_drive_low, sda_drive_low;
    logic       s_low = 1'b0;
    logic       sda_in;
    logic       scl_line;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic       mack_q[$];
    int         n_start = 0, n_stop = 0;

    always #5 clk = ~clk;

    assign sda_in   = !(sda_drive_low || s_low);
    assign scl_line = !scl_drive_low;

    i2cm_byte_ctrl u_i2cm_byte_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .sda_in        (sda_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] rom(input int i);
        return 8'h96 + 8'(i * 59);
    endfunction

    // ---------------- slave model and scoreboard monitor ----------------
    int         s_st = 0;   // 0 idle,1 addr,2 write,3 read,4 ignore,5 read-addr ack
    int         bitc = 0;
    int         idx = 0;
    logic [7:0] sh = 8'd0;
    logic [7:0] txb = 8'd0;
    logic       scl_prev = 1'b1, sda_prev = 1'b1;

    always @(scl_drive_low or sda_drive_low) begin
        logic scl_now, sda_now, m;
        scl_now = !scl_drive_low;
        sda_now = !(sda_drive_low || s_low);
        if (scl_now && scl_prev && !sda_now && sda_prev) begin
            n_start++; s_st = 1; bitc = 0; s_low = 1'b0;
        end else if (scl_now && scl_prev && sda_now && !sda_prev) begin
            n_stop++; s_st = 0; s_low = 1'b0;
        end else if (scl_now && !scl_prev) begin
            if (s_st != 0) begin
                if (bitc < 8) begin
                    sh = {sh[6:0], sda_now};
                end else if (s_st == 3) begin
                    m = sda_now;
                    if (mack_q.size() == 0) chk(1'b0, "R5 unexpected master ack slot", m, 0);
                    else begin
                        logic e;
                        e = mack_q.pop_front();
                        chk(m == e, "R5 master ack level on ninth clock", m, e);
                    end
                    if (!m) begin idx++; txb = rom(idx); end
                    else s_st = 4;
                end
                bitc++;
            end
        end else if (!scl_now && scl_prev) begin
            if (s_st != 0) begin
                if (bitc == 8) begin
                    if (s_st == 1 || s_st == 2) begin
                        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected byte on bus", sh, 0);
                        else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            chk(sh == e, "R2 byte seen by slave (MSB first)", sh, e);
                        end
                    end
                    if (s_st == 1) begin
                        if (sh[7:1] == SLV) begin
                            s_low = 1'b1;
                            if (sh[0]) begin s_st = 5; idx = 0; txb = rom(0); end
                            else s_st = 2;
                        end else begin
                            s_st = 4; s_low = 1'b0;
                        end
                    end else if (s_st == 2) begin
                        s_low = 1'b1;
                    end else begin
                        s_low = 1'b0;
                    end
                end else if (bitc == 9) begin
                    bitc = 0; s_low = 1'b0;
                    if (s_st == 5) s_st = 3;
                    if (s_st == 3) s_low = !txb[7];
                end else if (s_st == 3 && bitc >= 1 && bitc <= 7) begin
                    s_low = !txb[7 - bitc];
                end
            end
        end
        scl_prev = scl_now;
        sda_prev = !(sda_drive_low || s_low);
    end

    // ---------------- driver tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_pend(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(A_CTRL, v);
            if (v[4]) return;
        end
        chk(1'b0, tag, 0, 1);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, v);
            if (!v[5]) return;
        end
        chk(1'b0, tag, 1, 0);
    endtask

    task automatic scl_period(output longint p);
        realtime t0, t1;
        @(posedge scl_line); t0 = $realtime;
        @(posedge scl_line); t1 = $realtime;
        p = longint'((t1 - t0) / 10.0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        longint     p;
        bit         held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); chk(v == 8'h00, "R1 ctrl after reset", v, 0);
        rd(A_STAT, v); chk(v == 8'h00, "R1 status after reset", v, 0);
        rd(A_DATA, v); chk(v == 8'h00, "R1 data after reset", v, 0);
        rd(A_OWN,  v); chk(v == 8'h00, "R1 own address after reset", v, 0);
        chk(!scl_drive_low && !sda_drive_low && !irq, "R1 lines released, irq low",
            {irq, scl_drive_low, sda_drive_low}, 0);

        // R14 own address register
        wr(A_OWN, 8'h5A);
        rd(A_OWN, v); chk(v == 8'h5A, "R14 own address readback", v, 8'h5A);

        // R9 writing 1 to pending while clear does not set it
        wr(A_CTRL, 8'h10);
        rd(A_CTRL, v); chk(v[4] == 1'b0, "R9 pending not set by writing 1", v[4], 0);

        wr(A_CTRL, 8'hA0);   // ack on, irq on, prescaler 16, divider 0

        // R13 start request with output disabled
        wr(A_STAT, 8'hE0);
        held = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (scl_drive_low || sda_drive_low) held = 1'b0;
        end
        chk(held, "R13 no START while output disabled", !held, 0);
        rd(A_STAT, v); chk(v[5] == 1'b0, "R13 busy stays 0", v[5], 0);
        chk(n_start == 0, "R13 no START event", n_start, 0);

        // ---- write transaction: addr(W), 3 bytes, STOP ----
        wr(A_DATA, {SLV, 1'b0}); exp_q.push_back({SLV, 1'b0});
        wr(A_STAT, 8'hF0);
        rd(A_STAT, v); chk(v[5] == 1'b1, "R8 busy after START", v[5], 1);
        wait_pend("R3 pending after address byte");
        rd(A_STAT, v); chk(v[0] == 1'b0, "R4 ACK recorded for matching address", v[0], 0);
        chk(irq == 1'b1, "R12 irq with pending and enable", irq, 1);

        held = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!scl_drive_low) held = 1'b0;
        end
        chk(held, "R3 SCL held low during stall", !held, 0);

        wr(A_CTRL, 8'h90);   // pending bit written 1, irq disabled
        rd(A_CTRL, v); chk(v[4] == 1'b1, "R9 pending kept when writing 1", v[4], 1);
        chk(irq == 1'b0, "R12 irq low with enable off", irq, 0);
        repeat (20) @(negedge clk);
        chk(scl_drive_low == 1'b1, "R9 bus still stalled", !scl_drive_low, 0);

        wr(A_DATA, 8'h3C); exp_q.push_back(8'h3C);
        wr(A_CTRL, 8'hA0);
        scl_period(p); chk(p == 16, "R6 SCL period prescaler 16 divider 0", int'(p), 16);
        wait_pend("R3 pending after data byte 1");

        wr(A_DATA, 8'hC3); exp_q.push_back(8'hC3);
        wr(A_CTRL, 8'hA2);
        scl_period(p); chk(p == 48, "R6 SCL period prescaler 16 divider 2", int'(p), 48);
        wait_pend("R3 pending after data byte 2");

        wr(A_DATA, 8'h5E); exp_q.push_back(8'h5E);
        wr(A_CTRL, 8'hE0);
        scl_period(p); chk(p == 512, "R6 SCL period prescaler 512 divider 0", int'(p), 512);
        wait_pend("R3 pending after data byte 3");
        rd(A_STAT, v); chk(v[0] == 1'b0, "R4 ACK on data byte", v[0], 0);

        wr(A_STAT, 8'h90);    // STOP request
        wr(A_CTRL, 8'hA0);
        wait_idle("R10 STOP completes");
        chk(!scl_drive_low && !sda_drive_low, "R8 lines released after STOP",
            {scl_drive_low, sda_drive_low}, 0);
        chk(n_stop == 1, "R10 STOP seen on bus", n_stop, 1);

        // ---- address not acknowledged ----
        wr(A_DATA, 8'hC4); exp_q.push_back(8'hC4);
        wr(A_STAT, 8'hF0);
        wait_pend("R3 pending after unmatched address");
        rd(A_STAT, v); chk(v[0] == 1'b1, "R4 NACK recorded", v[0], 1);
        wr(A_STAT, 8'h90);
        wr(A_CTRL, 8'hA0);
        wait_idle("R10 STOP after NACK");

        // ---- register read: addr(W), reg, repeated START addr(R), 3 bytes ----
        wr(A_DATA, {SLV, 1'b0}); exp_q.push_back({SLV, 1'b0});
        wr(A_STAT, 8'hF0);
        wait_pend("R3 pending after address (read setup)");
        wr(A_DATA, 8'h07); exp_q.push_back(8'h07);
        wr(A_CTRL, 8'hA0);
        wait_pend("R3 pending after register byte");
        wr(A_DATA, {SLV, 1'b1}); exp_q.push_back({SLV, 1'b1});
        wr(A_STAT, 8'hB0);    // receive mode, repeated START
        wr(A_CTRL, 8'hA0);
        wait_pend("R11 pending after repeated START address");
        chk(n_start == 4, "R11 repeated START on bus", n_start, 4);
        rd(A_STAT, v); chk(v[0] == 1'b0, "R11 read address acknowledged", v[0], 0);

        for (int i = 0; i < 3; i++) begin
            bit last;
            last = (i == 2);
            mack_q.push_back(last);
            wr(A_CTRL, last ? 8'h20 : 8'hA0);
            wait_pend("R5 pending after received byte");
            rd(A_DATA, v);
            chk(v == rom(i), "R5 received byte in data register", v, rom(i));
        end
        wr(A_STAT, 8'h90);
        wr(A_CTRL, 8'hA0);
        wait_idle("R10 STOP after read");

        // R7 start/stop events only where requested; R2 scoreboard drained
        chk(n_start == 4, "R7 START event count", n_start, 4);
        chk(n_stop == 3, "R7 STOP event count", n_stop, 3);
        chk(exp_q.size() == 0, "R2 all expected bytes seen", exp_q.size(), 0);
        chk(mack_q.size() == 0, "R5 all ack slots seen", mack_q.size(), 0);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule